// File: doc/BRIEF.md
# NAND Boot Loader with Bad-Block Skipping

This block is a sequencer that pulls a boot image out of NAND flash into destination memory. Given a byte offset, a byte length and a destination base address, it walks the flash page by page from the page that holds the offset. For each page it sends a short command/address stream to a byte port. It then asks a decode engine for four subpage reads, one after another. Pages that belong to good blocks are committed, one after another, to consecutive destination slots. When the image is complete, when a read fails inside a good block, or when it runs out of flash, it ends with a one-cycle `done` pulse and an `ok` flag.

Block quality is judged only on the first page of each block, from whether that page reads cleanly and from its two leading spare bytes. Pages in bad blocks are still read but are thrown away. A load that starts partway through a block trusts that block. The byte-level flash cycles, the error-correcting decoder and the movement of page data sit behind the byte, decode and commit ports. The loader only orders them and keeps count.

All three outgoing requests (`nf_*`, `dec_req_*`, `commit_*`) follow valid/ready rules. The loader raises valid and holds it, with its payload unchanged, until it samples ready high on a rising edge. The transfer happens on that edge, and the partner may hold ready low for any number of cycles. At most one of the three valids is high at a time. `dec_done` and its status fields are a one-cycle report with no back-pressure.

Top module: `nand_boot_loader`

## Requirements
- R1: On `start` while idle, the first page is `offset / 2048` and the number of pages wanted is `size / 2048` rounded up. A `size` of 0 ends with `ok`=1 and no flash traffic. Pages are scanned in increasing order without gaps.
- R2: Each page read sends seven bytes on the byte port: 0x00 with `nf_is_cmd`=1, then two 0x00 bytes, then page address bits [7:0], [15:8], [23:16] (all with `nf_is_cmd`=0), and last 0x30 with `nf_is_cmd`=1.
- R3: After the address bytes, up to four decode requests are issued, each only after the previous one has reported. A subpage fails if `dec_done` arrives with `dec_fail`=1, or if `dec_done` is not seen in any of the POLL_LIMIT cycles after the request is accepted. A failed subpage ends the page with no further requests.
- R4: On a page whose number is a multiple of the block size (64 pages), the block becomes bad if the page failed or if `dec_spare0` or `dec_spare1` (reported with the first subpage) is not 0xFF. On every other page the block status is kept and the spare bytes are ignored. A start in the middle of a block counts that block as good.
- R5: A failed page in a good block ends the load with `ok`=0, and that page is not committed.
- R6: Every cleanly read page of a good block is committed once, in page order. Commit k of a run carries `commit_addr` = `dst_base` + 2048*k, and each commit lowers the pages still needed by one. Pages of bad blocks produce no commit.
- R7: The load ends with `ok`=1 as soon as no pages are still needed, with no further reads. Pages at or beyond page 524288 are never read, and reaching that limit with pages still needed ends with `ok`=0.
- R8: `max_corr` shows the largest value of (`dec_corr_cnt` + 1) over all subpages of the run that reported `dec_corr_flag`=1 and `dec_fail`=0. It is 0 for subpages without the flag, and it is cleared by each accepted start.
- R9: `busy` is high from the cycle after an accepted start until the cycle after `done`. `done` is a single-cycle pulse, `ok` holds its value until the next accepted start, and `start` has no effect while busy.
- R10: `nf_valid`, `dec_req_valid` and `commit_valid` each stay high with their payload unchanged until accepted, and no two of them are high at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a load (accepted only when idle) |
| offset | input | 32 | Byte offset of the image in flash |
| size | input | 32 | Image length in bytes |
| dst_base | input | 32 | Destination address of the first page |
| busy | output | 1 | Load in progress |
| done | output | 1 | One-cycle end-of-load pulse |
| ok | output | 1 | Result of the last load (1 = complete) |
| max_corr | output | 3 | Largest corrected-error count seen in the run |
| nf_valid | output | 1 | Command/address byte valid |
| nf_ready | input | 1 | Byte port accepts the byte |
| nf_is_cmd | output | 1 | Byte is a command (1) or an address (0) |
| nf_byte | output | 8 | Command or address byte |
| dec_req_valid | output | 1 | Request for one subpage decode read |
| dec_req_ready | input | 1 | Decode engine accepts the request |
| dec_done | input | 1 | Subpage decode finished (one cycle) |
| dec_fail | input | 1 | Decoder could not correct the subpage |
| dec_corr_flag | input | 1 | Decoder corrected at least one error |
| dec_corr_cnt | input | 2 | Corrected errors minus one |
| dec_spare0 | input | 8 | First spare byte of the page (valid with the first subpage) |
| dec_spare1 | input | 8 | Second spare byte of the page (valid with the first subpage) |
| commit_valid | output | 1 | Keep the decoded page at `commit_addr` |
| commit_ready | input | 1 | Destination accepts the page |
| commit_addr | output | 32 | Destination address of the kept page |

## Verification
The bench builds the loader with 8 pages per block and a 16-cycle poll window, and keeps the default page limit and page size. Short blocks put block boundaries, bad-block markers and mid-block starts within a few dozen pages. A short poll window makes timed-out subpages cheap, and replies on the last allowed cycle show up often. Because the page limit is the full default, the bench reaches it by starting a few pages below the last page. That start also puts non-zero values in the upper page-address bytes.

// File: rtl/nbl_pkg.sv
package nbl_pkg;

  localparam logic [7:0] CMD_READ_SETUP = 8'h00;
  localparam logic [7:0] CMD_READ_GO    = 8'h30;
  localparam logic [7:0] SPARE_BLANK    = 8'hFF;
  localparam int         ADDR_SEQ_LEN   = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_ADDR,
    ST_SUBS,
    ST_COMMIT,
    ST_FINISH
  } ldr_state_t;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_REQ,
    PH_WAIT
  } sub_phase_t;

  typedef struct packed {
    logic       failed;
    logic       marks_ok;
    logic [2:0] corr;
  } page_result_t;

endpackage

// File: rtl/nbl_addr_seq.sv
module nbl_addr_seq
  import nbl_pkg::*;
#(
  parameter int PG_W = 22
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  logic [PG_W-1:0] page,
  output logic            nf_valid,
  input  logic            nf_ready,
  output logic            nf_is_cmd,
  output logic [7:0]      nf_byte,
  output logic            fin
);
  localparam logic [2:0] LAST_IDX = 3'(ADDR_SEQ_LEN - 1);

  logic        active;
  logic [2:0]  idx;
  logic [23:0] pg24;

  assign pg24 = 24'(page);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
    end else if (go) begin
      active <= 1'b1;
      idx    <= '0;
    end else if (active && nf_ready) begin
      if (idx == LAST_IDX) begin
        active <= 1'b0;
        idx    <= '0;
      end else begin
        idx <= idx + 3'd1;
      end
    end
  end

  always_comb begin
    nf_is_cmd = 1'b0;
    nf_byte   = 8'h00;
    case (idx)
      3'd0: begin nf_is_cmd = 1'b1; nf_byte = CMD_READ_SETUP; end
      3'd1, 3'd2: nf_byte = 8'h00;
      3'd3: nf_byte = pg24[7:0];
      3'd4: nf_byte = pg24[15:8];
      3'd5: nf_byte = pg24[23:16];
      default: begin nf_is_cmd = 1'b1; nf_byte = CMD_READ_GO; end
    endcase
  end

  assign nf_valid = active;
  assign fin      = active && nf_ready && (idx == LAST_IDX);

endmodule

// File: rtl/nbl_sub_reader.sv
module nbl_sub_reader
  import nbl_pkg::*;
#(
  parameter int SUBPAGES   = 4,
  parameter int POLL_LIMIT = 5000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  output logic         dec_req_valid,
  input  logic         dec_req_ready,
  input  logic         dec_done,
  input  logic         dec_fail,
  input  logic         dec_corr_flag,
  input  logic [1:0]   dec_corr_cnt,
  input  logic [7:0]   dec_spare0,
  input  logic [7:0]   dec_spare1,
  output logic         fin,
  output page_result_t res
);
  localparam int SW = (SUBPAGES > 1) ? $clog2(SUBPAGES) : 1;
  localparam int PW = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT) : 1;
  localparam logic [SW-1:0] LAST_SUB  = SW'(SUBPAGES - 1);
  localparam logic [PW-1:0] LAST_POLL = PW'(POLL_LIMIT - 1);

  sub_phase_t   phase;
  logic [SW-1:0] sub;
  logic [PW-1:0] poll;
  logic [2:0]    this_corr;

  assign this_corr = dec_corr_flag ? ({1'b0, dec_corr_cnt} + 3'd1) : 3'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      sub   <= '0;
      poll  <= '0;
      fin   <= 1'b0;
      res   <= '0;
    end else begin
      fin <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (go) begin
            phase        <= PH_REQ;
            sub          <= '0;
            res.failed   <= 1'b0;
            res.marks_ok <= 1'b0;
            res.corr     <= 3'd0;
          end
        end
        PH_REQ: begin
          if (dec_req_ready) begin
            phase <= PH_WAIT;
            poll  <= '0;
          end
        end
        default: begin
          if (dec_done) begin
            if (dec_fail) begin
              res.failed <= 1'b1;
              fin        <= 1'b1;
              phase      <= PH_IDLE;
            end else begin
              if (this_corr > res.corr) res.corr <= this_corr;
              if (sub == '0)
                res.marks_ok <= (dec_spare0 == SPARE_BLANK) && (dec_spare1 == SPARE_BLANK);
              if (sub == LAST_SUB) begin
                fin   <= 1'b1;
                phase <= PH_IDLE;
              end else begin
                sub   <= sub + 1'b1;
                phase <= PH_REQ;
              end
            end
          end else if (poll == LAST_POLL) begin
            res.failed <= 1'b1;
            fin        <= 1'b1;
            phase      <= PH_IDLE;
          end else begin
            poll <= poll + 1'b1;
          end
        end
      endcase
    end
  end

  assign dec_req_valid = (phase == PH_REQ);

endmodule

// File: rtl/nbl_block_judge.sv
module nbl_block_judge
  import nbl_pkg::*;
#(
  parameter int PG_W     = 22,
  parameter int BLK_LOG2 = 6
) (
  input  logic [PG_W-1:0] page,
  input  logic            cur_good,
  input  page_result_t    res,
  output logic            next_good,
  output logic            keep,
  output logic            abort
);
  logic first;

  assign first     = (page[BLK_LOG2-1:0] == '0);
  assign next_good = first ? (!res.failed && res.marks_ok) : cur_good;
  assign abort     = next_good && res.failed;
  assign keep      = next_good && !res.failed;

endmodule

// File: rtl/nand_boot_loader.sv
module nand_boot_loader
  import nbl_pkg::*;
#(
  parameter int ADDR_W          = 32,
  parameter int PAGE_BYTES      = 2048,
  parameter int PAGES_PER_BLOCK = 64,
  parameter int PAGE_LIMIT      = 524288,
  parameter int SUBPAGES        = 4,
  parameter int POLL_LIMIT      = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] offset,
  input  logic [ADDR_W-1:0] size,
  input  logic [ADDR_W-1:0] dst_base,
  output logic              busy,
  output logic              done,
  output logic              ok,
  output logic [2:0]        max_corr,
  output logic              nf_valid,
  input  logic              nf_ready,
  output logic              nf_is_cmd,
  output logic [7:0]        nf_byte,
  output logic              dec_req_valid,
  input  logic              dec_req_ready,
  input  logic              dec_done,
  input  logic              dec_fail,
  input  logic              dec_corr_flag,
  input  logic [1:0]        dec_corr_cnt,
  input  logic [7:0]        dec_spare0,
  input  logic [7:0]        dec_spare1,
  output logic              commit_valid,
  input  logic              commit_ready,
  output logic [ADDR_W-1:0] commit_addr
);
  localparam int PB_LOG2  = $clog2(PAGE_BYTES);
  localparam int BLK_LOG2 = $clog2(PAGES_PER_BLOCK);
  localparam int PG_W     = ADDR_W - PB_LOG2 + 1;
  localparam int CNT_W    = ADDR_W - PB_LOG2 + 1;
  localparam logic [PG_W-1:0]   PG_END  = PG_W'(PAGE_LIMIT);
  localparam logic [ADDR_W-1:0] PG_STEP = ADDR_W'(PAGE_BYTES);

  ldr_state_t        state;
  logic [PG_W-1:0]   page;
  logic [CNT_W-1:0]  left;
  logic              good;
  logic [ADDR_W-1:0] dst;
  logic [2:0]        maxc;
  logic              ok_q;

  logic         addr_go, addr_fin, sub_go, sub_fin;
  page_result_t res;
  logic         next_good, keep, abort;
  logic [CNT_W-1:0] need;

  assign need = CNT_W'(size >> PB_LOG2) + CNT_W'(size[PB_LOG2-1:0] != '0);

  assign addr_go = (state == ST_CHECK) && (left != '0) && (page < PG_END);
  assign sub_go  = (state == ST_ADDR) && addr_fin;

  nbl_addr_seq #(.PG_W(PG_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .go(addr_go), .page(page),
    .nf_valid(nf_valid), .nf_ready(nf_ready), .nf_is_cmd(nf_is_cmd),
    .nf_byte(nf_byte), .fin(addr_fin)
  );

  nbl_sub_reader #(.SUBPAGES(SUBPAGES), .POLL_LIMIT(POLL_LIMIT)) u_sub (
    .clk(clk), .rst_n(rst_n), .go(sub_go),
    .dec_req_valid(dec_req_valid), .dec_req_ready(dec_req_ready),
    .dec_done(dec_done), .dec_fail(dec_fail), .dec_corr_flag(dec_corr_flag),
    .dec_corr_cnt(dec_corr_cnt), .dec_spare0(dec_spare0), .dec_spare1(dec_spare1),
    .fin(sub_fin), .res(res)
  );

  nbl_block_judge #(.PG_W(PG_W), .BLK_LOG2(BLK_LOG2)) u_judge (
    .page(page), .cur_good(good), .res(res),
    .next_good(next_good), .keep(keep), .abort(abort)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      page  <= '0;
      left  <= '0;
      good  <= 1'b1;
      dst   <= '0;
      maxc  <= 3'd0;
      ok_q  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            page  <= PG_W'(offset >> PB_LOG2);
            left  <= need;
            good  <= 1'b1;
            dst   <= dst_base;
            maxc  <= 3'd0;
            ok_q  <= 1'b0;
            state <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (left == '0) begin
            ok_q  <= 1'b1;
            state <= ST_FINISH;
          end else if (page >= PG_END) begin
            ok_q  <= 1'b0;
            state <= ST_FINISH;
          end else begin
            state <= ST_ADDR;
          end
        end
        ST_ADDR: begin
          if (addr_fin) state <= ST_SUBS;
        end
        ST_SUBS: begin
          if (sub_fin) begin
            if (res.corr > maxc) maxc <= res.corr;
            good <= next_good;
            if (abort) begin
              ok_q  <= 1'b0;
              state <= ST_FINISH;
            end else if (keep) begin
              state <= ST_COMMIT;
            end else begin
              page  <= page + 1'b1;
              state <= ST_CHECK;
            end
          end
        end
        ST_COMMIT: begin
          if (commit_ready) begin
            dst   <= dst + PG_STEP;
            left  <= left - 1'b1;
            page  <= page + 1'b1;
            state <= ST_CHECK;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy         = (state != ST_IDLE);
  assign done         = (state == ST_FINISH);
  assign ok           = ok_q;
  assign max_corr     = maxc;
  assign commit_valid = (state == ST_COMMIT);
  assign commit_addr  = dst;

endmodule

// File: rtl/nbl_checker.sv
module nbl_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic [2:0]        max_corr,
  input logic              nf_valid,
  input logic              nf_ready,
  input logic              nf_is_cmd,
  input logic [7:0]        nf_byte,
  input logic              dec_req_valid,
  input logic              dec_req_ready,
  input logic              commit_valid,
  input logic              commit_ready,
  input logic [ADDR_W-1:0] commit_addr
);
  // R10
  nf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nf_valid && !nf_ready |=> nf_valid && $stable(nf_byte) && $stable(nf_is_cmd));

  // R10
  commit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid && !commit_ready |=> commit_valid && $stable(commit_addr));

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_req_valid && !dec_req_ready |=> dec_req_valid);

  // R10
  one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({nf_valid, dec_req_valid, commit_valid}));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !nf_valid && !dec_req_valid && !commit_valid);

  // R8
  corr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    max_corr <= 3'd4);

  // R2
  cmd_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nf_valid && nf_is_cmd |-> (nf_byte == 8'h00) || (nf_byte == 8'h30));

endmodule

bind nand_boot_loader nbl_checker #(.ADDR_W(ADDR_W)) u_nbl_checker (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .max_corr(max_corr),
  .nf_valid(nf_valid), .nf_ready(nf_ready), .nf_is_cmd(nf_is_cmd), .nf_byte(nf_byte),
  .dec_req_valid(dec_req_valid), .dec_req_ready(dec_req_ready),
  .commit_valid(commit_valid), .commit_ready(commit_ready), .commit_addr(commit_addr)
);

// File: tb/test_nand_boot_loader.sv
module test_nand_boot_loader;
  localparam int PPB   = 8;
  localparam int POLL  = 16;
  localparam int LIMIT = 524288;
  localparam int PB    = 2048;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, start = 1'b0;
  logic [31:0] offset = '0, size = '0, dst_base = '0;
  logic busy, done, ok;
  logic [2:0] max_corr;
  logic nf_valid, nf_ready = 1'b0, nf_is_cmd;
  logic [7:0] nf_byte;
  logic dec_req_valid, dec_req_ready = 1'b0;
  logic dec_done = 1'b0, dec_fail = 1'b0, dec_corr_flag = 1'b0;
  logic [1:0] dec_corr_cnt = '0;
  logic [7:0] dec_spare0 = 8'hFF, dec_spare1 = 8'hFF;
  logic commit_valid, commit_ready = 1'b0;
  logic [31:0] commit_addr;

  nand_boot_loader #(.PAGES_PER_BLOCK(PPB), .POLL_LIMIT(POLL)) i_nand_boot_loader (
    .clk(clk), .rst_n(rst_n), .start(start), .offset(offset), .size(size),
    .dst_base(dst_base), .busy(busy), .done(done), .ok(ok), .max_corr(max_corr),
    .nf_valid(nf_valid), .nf_ready(nf_ready), .nf_is_cmd(nf_is_cmd), .nf_byte(nf_byte),
    .dec_req_valid(dec_req_valid), .dec_req_ready(dec_req_ready),
    .dec_done(dec_done), .dec_fail(dec_fail), .dec_corr_flag(dec_corr_flag),
    .dec_corr_cnt(dec_corr_cnt), .dec_spare0(dec_spare0), .dec_spare1(dec_spare1),
    .commit_valid(commit_valid), .commit_ready(commit_ready), .commit_addr(commit_addr)
  );

  int total = 0, bad = 0;
  bit hung = 0;
  logic [31:0] scen_seed = 32'h1;
  bit mode_fail = 0;

  task automatic check(input bit cond, input string tag, input longint act, input longint exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // page attribute model
  function automatic logic [31:0] mix(input logic [31:0] x);
    logic [31:0] h;
    h = x * 32'h9E3779B1;
    h = h ^ (h >> 15);
    h = h * 32'h85EBCA6B;
    h = h ^ (h >> 13);
    return h;
  endfunction
  function automatic logic [31:0] h1f(input int p); return mix(p ^ scen_seed); endfunction
  function automatic logic [31:0] h2f(input int p); return mix(h1f(p) ^ 32'h5BD1E995); endfunction
  function automatic bit is_first(input int p); return (p % PPB) == 0; endfunction
  function automatic bit pg_fails(input int p);
    logic [31:0] h = h1f(p);
    return (mode_fail && h[4:0] == 0) || (is_first(p) && h[8:6] == 0);
  endfunction
  function automatic int fail_sub(input int p);
    logic [31:0] h = h1f(p);
    return int'(h[10:9]);
  endfunction
  function automatic bit fail_tmo(input int p);
    logic [31:0] h = h1f(p);
    return h[11];
  endfunction
  function automatic logic [7:0] spare(input int p, input int which);
    logic [31:0] h = h1f(p);
    if (is_first(p)) begin
      if (h[13:12] == 0 && h[14] == which[0]) return {1'b0, h[21:15]};
      return 8'hFF;
    end
    return (which == 0) ? h[21:14] : h[29:22];
  endfunction
  function automatic bit cflag(input int p, input int s);
    logic [31:0] h = h2f(p);
    return h[s];
  endfunction
  function automatic int ccnt(input int p, input int s);
    logic [31:0] h = h2f(p);
    return int'(h[4+2*s +: 2]);
  endfunction
  function automatic int cdelay(input int p, input int s);
    logic [31:0] h = h2f(p);
    return int'(h[12+4*s +: 4]) % POLL + 1;
  endfunction
  function automatic int exp_subs(input int p);
    return pg_fails(p) ? fail_sub(p) + 1 : 4;
  endfunction

  // expected run
  int m_ok, m_maxc, m_ncom, m_scanned;
  int m_com [64];
  task automatic run_model(input logic [31:0] off, input logic [31:0] sz);
    int page, left, good, f;
    bit stop;
    page = int'(off / PB);
    left = int'(sz / PB) + ((sz % PB) != 0 ? 1 : 0);
    good = 1; m_maxc = 0; m_ncom = 0; m_scanned = 0; stop = 0; m_ok = 0;
    while (!stop && left > 0 && page < LIMIT) begin
      m_scanned++;
      f = 0;
      for (int s = 0; s < 4; s++) begin
        if (pg_fails(page) && fail_sub(page) == s) begin f = 1; break; end
        if (cflag(page, s) && ccnt(page, s) + 1 > m_maxc) m_maxc = ccnt(page, s) + 1;
      end
      if (is_first(page)) good = (!f && spare(page, 0) == 8'hFF && spare(page, 1) == 8'hFF) ? 1 : 0;
      if (good && f) stop = 1;
      else begin
        if (good) begin
          if (m_ncom < 64) m_com[m_ncom] = page;
          m_ncom++;
          left--;
        end
        page++;
      end
    end
    m_ok = (!stop && left == 0) ? 1 : 0;
  endtask

  // responder for the three ports
  bit sv_nf_v, sv_nf_r, sv_nf_c, sv_rq_v, sv_rq_r, sv_cm_v, sv_cm_r;
  logic [7:0] sv_nf_b;
  logic [31:0] sv_cm_a;
  logic [7:0] ab [7];
  bit ac [7];
  int aidx, cur_page, exp_next, sub_cnt, pend_sub, wait_cd, scanned, ncom;
  int err_addr, err_sub, err_hold;
  bit page_open;
  int com_pages [64];
  logic [31:0] com_addrs [64];

  task automatic close_page();
    if (page_open && sub_cnt != exp_subs(cur_page)) err_sub++;
    page_open = 0;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (sv_nf_v && !sv_nf_r && (!nf_valid || nf_byte != sv_nf_b || nf_is_cmd != sv_nf_c)) err_hold++;
      if (sv_cm_v && !sv_cm_r && (!commit_valid || commit_addr != sv_cm_a)) err_hold++;
      if (sv_rq_v && !sv_rq_r && !dec_req_valid) err_hold++;
      if (sv_nf_v && sv_nf_r) begin
        ab[aidx] = sv_nf_b; ac[aidx] = sv_nf_c; aidx++;
        if (aidx == 7) begin
          int pg;
          pg = int'({ab[5], ab[4], ab[3]});
          if (!(ab[0] == 8'h00 && ac[0] && ab[1] == 8'h00 && !ac[1] && ab[2] == 8'h00 && !ac[2] &&
                !ac[3] && !ac[4] && !ac[5] && ab[6] == 8'h30 && ac[6] && pg == exp_next)) err_addr++;
          close_page();
          cur_page = pg; exp_next = pg + 1; sub_cnt = 0; page_open = 1; scanned++; aidx = 0;
        end
      end
      if (sv_rq_v && sv_rq_r) begin
        pend_sub = sub_cnt; sub_cnt++;
        if (pg_fails(cur_page) && fail_tmo(cur_page) && fail_sub(cur_page) == pend_sub) wait_cd = 0;
        else wait_cd = cdelay(cur_page, pend_sub);
      end
      if (sv_cm_v && sv_cm_r) begin
        if (ncom < 64) begin com_pages[ncom] = cur_page; com_addrs[ncom] = sv_cm_a; end
        ncom++;
      end
      if (wait_cd == 1) begin
        dec_done      = 1'b1;
        dec_fail      = pg_fails(cur_page) && fail_sub(cur_page) == pend_sub;
        dec_corr_flag = cflag(cur_page, pend_sub);
        dec_corr_cnt  = 2'(ccnt(cur_page, pend_sub));
        dec_spare0    = spare(cur_page, 0);
        dec_spare1    = spare(cur_page, 1);
      end else begin
        dec_done = 1'b0; dec_fail = 1'b0; dec_corr_flag = 1'b0;
      end
      if (wait_cd > 0) wait_cd--;
      nf_ready      = ($urandom % 3) != 0;
      dec_req_ready = $urandom % 2;
      commit_ready  = $urandom % 2;
      sv_nf_v = nf_valid; sv_nf_r = nf_ready; sv_nf_b = nf_byte; sv_nf_c = nf_is_cmd;
      sv_rq_v = dec_req_valid; sv_rq_r = dec_req_ready;
      sv_cm_v = commit_valid; sv_cm_r = commit_ready; sv_cm_a = commit_addr;
    end
  end

  task automatic run_scen(input logic [31:0] off, input logic [31:0] sz, input logic [31:0] dst,
                          input logic [31:0] seed, input bit mf, input bit late_start);
    int n, errc;
    if (hung) return;
    scen_seed = seed; mode_fail = mf;
    run_model(off, sz);
    @(posedge clk); #1;
    aidx = 0; exp_next = int'(off / PB); sub_cnt = 0; page_open = 0; scanned = 0; ncom = 0;
    err_addr = 0; err_sub = 0; err_hold = 0; wait_cd = 0;
    @(negedge clk);
    start = 1'b1; offset = off; size = sz; dst_base = dst;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R9 busy after start", busy, 1);
    if (late_start) begin
      repeat (40) @(negedge clk);
      start = 1'b1; offset = off + 32'h0010_0000; size = 32'd3; dst_base = ~dst;
      @(negedge clk);
      start = 1'b0;
    end
    n = 0;
    while (!done && n < 30000) begin @(negedge clk); n++; end
    if (!done) begin
      check(1'b0, "R9 watchdog", 0, 1);
      hung = 1;
      return;
    end
    if (mf && m_ok == 0 && m_scanned > 0) check(ok == m_ok[0], "R5 abort result", ok, m_ok);
    else check(ok == m_ok[0], "R7 load result", ok, m_ok);
    check(int'(max_corr) == m_maxc, "R8 max corrected count", max_corr, m_maxc);
    @(negedge clk); #1;
    check(busy == 1'b0, "R9 idle after done", busy, 0);
    close_page();
    check(scanned == m_scanned, "R1 pages scanned", scanned, m_scanned);
    check(err_addr == 0, "R2 address sequence", err_addr, 0);
    check(err_sub == 0, "R3 subpage requests", err_sub, 0);
    check(err_hold == 0, "R10 valid hold", err_hold, 0);
    check(ncom == m_ncom, "R6 commit count", ncom, m_ncom);
    errc = 0;
    for (int i = 0; i < ncom && i < m_ncom && i < 64; i++)
      if (com_pages[i] != m_com[i]) errc++;
    check(errc == 0, "R4 kept pages", errc, 0);
    errc = 0;
    for (int i = 0; i < ncom && i < 64; i++)
      if (com_addrs[i] != dst + 32'(i * PB)) errc++;
    check(errc == 0, "R6 commit addresses", errc, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && nf_valid == 0 && dec_req_valid == 0 && commit_valid == 0,
          "R9 reset state", busy, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // directed corners
    run_scen(32'd0, 32'd1, 32'h8000_0000, 32'h11, 0, 0);              // R1 one byte -> one page
    run_scen(32'(3 * PB + 100), 32'(5 * PB), 32'h1000, 32'h22, 0, 0);   // R4 mid-block start
    run_scen(32'((LIMIT - 3) * PB), 32'(10 * PB), 32'h0, 32'h33, 0, 0); // R7 page limit, R2 high bytes
    run_scen(32'(17 * PB), 32'(12 * PB + 1), 32'h4000, 32'h44, 0, 1);  // R9 start while busy
    // random mix
    for (int k = 0; k < 22; k++) begin
      logic [31:0] o, s, d;
      o = 32'(($urandom % 200) * PB + ($urandom % PB));
      s = 32'($urandom % (20 * PB)) + 32'd1;
      d = $urandom & 32'hFFFF_F800;
      run_scen(o, s, d, $urandom, (k % 3) == 0, 0);
    end
    // R5 aborts with failures enabled
    for (int k = 0; k < 4; k++)
      run_scen(32'(($urandom % 64) * PB), 32'(24 * PB), 32'h2000_0000, 32'h500 + k, 1, 0);
    run_scen(32'(9 * PB), 32'd0, 32'h0, 32'h66, 0, 0);                 // R1 size zero, R8 clear
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1900000;
    check(1'b0, "R9 global watchdog", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule